// File: doc/BRIEF.md
# Indirect Coefficient Memory Access Port

This block gives a register bus a window onto two coefficient memories that are too large to map word by word. Each memory is reached through a pair of 32-bit registers. A control register holds an address pointer and the mode of the next accesses. A data register moves one word per access. Software writes the control register once to choose a start word and a direction. It then streams any number of data-register writes or reads, one per clock cycle if it likes, and the pointer steps through the memory by itself.

Two instances sit behind one bus. The wide one holds 32-bit signed gains. The narrow one holds 5-bit shift amounts. Each memory is laid out as 8 channels, with a fixed number of words per channel: 62 gain words and 14 shift words, so channel n begins at n*62 and n*14. Reads have side effects, because a data read advances the pointer. For that reason the read path has a fixed latency and no busy flag. The port and the memories run on one clock.

Top module: `coef_port_top`

## Requirements
- R1: After reset, reading either control register returns 0x00004000: sequential mode on, load flag clear, direction read, pointer 0. Register select is bus_addr[1] (0 = gain memory, 1 = shift memory) and bus_addr[0] (0 = control, 1 = data).
- R2: A control write with bit 13 set loads the pointer from bits [9:0]. A value at or beyond the memory depth loads 0. A control read returns bit 14 = sequential, bit 13 = load flag as last written, bit 12 = direction (1 = write) and the current pointer in bits [9:0], with all other bits 0.
- R3: A control write with bit 13 clear updates the mode bits and leaves the pointer unchanged.
- R4: In write direction with sequential mode, each data write stores the low word bits at the pointer and advances the pointer by one.
- R5: In read direction with sequential mode, each data read returns the word at the pointer and advances it. Reads on consecutive cycles return consecutive words.
- R6: With sequential mode off (bit 14 clear), data accesses leave the pointer unchanged, so repeated writes hit the same word.
- R7: Advancing from the last word (gain 495, shift 111) wraps the pointer to 0.
- R8: A data write while the direction is read changes neither the memory nor the pointer.
- R9: A data read while the direction is write returns 0 and does not move the pointer.
- R10: The shift memory keeps only bits [4:0] of a written word and returns them zero-extended to 32 bits.
- R11: Read data and bus_rvalid appear two clock edges after the edge that samples bus_rd. bus_rvalid is high for exactly one cycle per read.
- R12: If bus_wr and bus_rd are both high in one cycle, only the write is performed. No read data is returned and the pointer moves at most once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | [1] memory select, [0] control/data select |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, two cycles after bus_rd |
| bus_rdata | output | 32 | Read data |

## Verification
On every cycle, the embedded assertions check the pointer behaviour: it stays inside the memory, a load takes the requested or clamped address, it holds when neither a load nor a step occurs, and it wraps at the last word. They also check the read pipeline: every valid has a read two cycles earlier, a read in write direction yields zero, and the two memories never answer at once. Only the bench scenarios can show that stored words come back intact through a whole write-then-read sequence, including the 5-bit truncation. The same holds for dropped writes in read direction, back-to-back bursts and the combined-strobe case.

// File: rtl/coef_pkg.sv
package coef_pkg;
  // Control word bit positions (decoded by software, so fixed)
  localparam int SEQ_BIT  = 14;
  localparam int LOAD_BIT = 13;
  localparam int DIR_BIT  = 12;
  localparam int ADDR_W   = 10;
  localparam logic [31:0] CTRL_RESET = 32'h0000_4000;

  // Kind of read in flight, stage one of the read pipeline
  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_CTRL = 2'd1,
    RK_DATA = 2'd2,
    RK_ZERO = 2'd3
  } rd_kind_t;

  typedef struct packed {
    logic seq;
    logic load;
    logic wr_dir;
  } ctrl_mode_t;

  function automatic logic [31:0] pack_ctrl(ctrl_mode_t m, logic [ADDR_W-1:0] a);
    logic [31:0] w;
    w = '0;
    w[SEQ_BIT]  = m.seq;
    w[LOAD_BIT] = m.load;
    w[DIR_BIT]  = m.wr_dir;
    w[ADDR_W-1:0] = a;
    return w;
  endfunction
endpackage

// File: rtl/coef_ram.sv
module coef_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 496,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [PW-1:0] addr,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  q
);
  logic [W-1:0] mem [DEPTH];

  // Single-port, synchronous read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    if (re) q <= mem[addr];
  end
endmodule

// File: rtl/coef_ptr.sv
module coef_ptr #(
  parameter int DEPTH = 496,
  parameter int AW    = 10,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          step,
  output logic [PW-1:0] ptr
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0] load_val;
  assign load_val = (32'(load_addr) < DEPTH) ? PW'(load_addr) : '0;

  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= (ptr == LAST) ? '0 : ptr + PW'(1);
  end

  // R2: the pointer takes the requested address, or 0 when out of range
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    load |=> (32'(ptr) == ((32'($past(load_addr)) < DEPTH) ? 32'($past(load_addr)) : 0)));
  // R2: the pointer never leaves the memory
  a_r2_bound: assert property (@(posedge clk) disable iff (rst)
    32'(ptr) < DEPTH);
  // R3 / R6: without a load or a step the pointer holds
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(ptr));
  // R7: stepping past the last word wraps to 0
  a_r7_wrap: assert property (@(posedge clk) disable iff (rst)
    (!load && step && ptr == LAST) |=> (ptr == '0));
endmodule

// File: rtl/coef_port.sv
module coef_port
  import coef_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 496,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctrl_we,
  input  logic        data_we,
  input  logic        ctrl_re,
  input  logic        data_re,
  input  logic [31:0] wdata,
  output logic        rvalid,
  output logic [31:0] rdata
);
  ctrl_mode_t    mode_q;
  logic [PW-1:0] ptr;
  logic          ram_we, ram_re, step;
  logic [W-1:0]  ram_q;

  // Control register mode bits
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q.seq    <= CTRL_RESET[SEQ_BIT];
      mode_q.load   <= CTRL_RESET[LOAD_BIT];
      mode_q.wr_dir <= CTRL_RESET[DIR_BIT];
    end else if (ctrl_we) begin
      mode_q.seq    <= wdata[SEQ_BIT];
      mode_q.load   <= wdata[LOAD_BIT];
      mode_q.wr_dir <= wdata[DIR_BIT];
    end
  end

  // Data register decode: accesses against the direction do nothing
  assign ram_we = data_we &&  mode_q.wr_dir;
  assign ram_re = data_re && !mode_q.wr_dir;
  assign step   = mode_q.seq && (ram_we || ram_re);

  coef_ptr #(.DEPTH(DEPTH), .AW(ADDR_W), .PW(PW)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .load      (ctrl_we && wdata[LOAD_BIT]),
    .load_addr (wdata[ADDR_W-1:0]),
    .step      (step),
    .ptr       (ptr)
  );

  coef_ram #(.W(W), .DEPTH(DEPTH), .PW(PW)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .re   (ram_re),
    .addr (ptr),
    .wd   (wdata[W-1:0]),
    .q    (ram_q)
  );

  // Read pipeline, stage one: classify and snapshot the control word
  rd_kind_t    kind_q;
  logic [31:0] snap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= RK_NONE;
      snap_q <= '0;
    end else begin
      if (ctrl_re)                          kind_q <= RK_CTRL;
      else if (data_re && mode_q.wr_dir)    kind_q <= RK_ZERO;
      else if (data_re)                     kind_q <= RK_DATA;
      else                                  kind_q <= RK_NONE;
      snap_q <= pack_ctrl(mode_q, ADDR_W'(ptr));
    end
  end

  // Stage two: registered output
  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= (kind_q != RK_NONE);
      case (kind_q)
        RK_CTRL: rdata <= snap_q;
        RK_DATA: rdata <= 32'(ram_q);
        default: rdata <= '0;
      endcase
    end
  end

  // R11: every valid answers a read two edges earlier
  a_r11_latency: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(ctrl_re || data_re, 2));
  // R11: every read produces a valid two edges later
  a_r11_answer: assert property (@(posedge clk) disable iff (rst)
    (ctrl_re || data_re) |=> ##1 rvalid);
  // R9: a data read in write direction returns zero
  a_r9_zero: assert property (@(posedge clk) disable iff (rst)
    (data_re && !ctrl_re && mode_q.wr_dir) |=> ##1 (rdata == 32'd0));
endmodule

// File: rtl/coef_port_top.sv
module coef_port_top #(
  parameter int CHANNELS    = 8,
  parameter int GAIN_WORDS  = 62,
  parameter int SHIFT_WORDS = 14,
  parameter int GAIN_W      = 32,
  parameter int SHIFT_W     = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic        bus_rvalid,
  output logic [31:0] bus_rdata
);
  localparam int NMEM = 2;

  logic        rd_eff;
  logic [NMEM-1:0] valid_v;
  logic [31:0] data_v [NMEM];

  // A write in the same cycle wins; the read is dropped
  assign rd_eff = bus_rd && !bus_wr;

  for (genvar g = 0; g < NMEM; g++) begin : g_mem
    localparam int W_G = (g == 0) ? GAIN_W : SHIFT_W;
    localparam int D_G = CHANNELS * ((g == 0) ? GAIN_WORDS : SHIFT_WORDS);
    logic hit;
    assign hit = (bus_addr[1] == 1'(g));

    coef_port #(.W(W_G), .DEPTH(D_G)) u_port (
      .clk     (clk),
      .rst     (rst),
      .ctrl_we (hit && bus_wr && !bus_addr[0]),
      .data_we (hit && bus_wr &&  bus_addr[0]),
      .ctrl_re (hit && rd_eff && !bus_addr[0]),
      .data_re (hit && rd_eff &&  bus_addr[0]),
      .wdata   (bus_wdata),
      .rvalid  (valid_v[g]),
      .rdata   (data_v[g])
    );
  end

  always_comb begin
    bus_rvalid = |valid_v;
    bus_rdata  = '0;
    for (int i = 0; i < NMEM; i++)
      if (valid_v[i]) bus_rdata = bus_rdata | data_v[i];
  end

  // R12: at most one memory answers in any cycle
  a_r12_one_source: assert property (@(posedge clk) disable iff (rst)
    $onehot0(valid_v));
  // R12: a cycle with both strobes yields no read data two edges later
  a_r12_drop: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_rd) |=> ##1 !bus_rvalid);
endmodule

// File: tb/sim_coef_port_top.sv
module sim_coef_port_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;

  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  coef_port_top u0 (.*);

  // Vector: {op(1: 1=read-check), req(4), addr(2), data(32), expected(32)}
  localparam int NV = 39;
  localparam logic [70:0] VEC [NV] = '{
    {1'b0,4'd4, 2'd0,32'h0000703E,32'h0},           // R4 seq write, start channel 1
    {1'b0,4'd4, 2'd1,32'hDEADBEEF,32'h0},
    {1'b0,4'd4, 2'd1,32'h80000001,32'h0},
    {1'b1,4'd4, 2'd0,32'h0,32'h00007040},           // R4 pointer advanced by 2
    {1'b0,4'd5, 2'd0,32'h0000603E,32'h0},           // R5 seq read
    {1'b1,4'd5, 2'd1,32'h0,32'hDEADBEEF},
    {1'b1,4'd5, 2'd1,32'h0,32'h80000001},
    {1'b1,4'd5, 2'd0,32'h0,32'h00006040},
    {1'b0,4'd10,2'd2,32'h0000700E,32'h0},           // R10 shift memory, channel 1
    {1'b0,4'd10,2'd3,32'hFFFFFFFF,32'h0},
    {1'b0,4'd10,2'd3,32'h00000012,32'h0},
    {1'b0,4'd10,2'd2,32'h0000600E,32'h0},
    {1'b1,4'd10,2'd3,32'h0,32'h0000001F},
    {1'b1,4'd10,2'd3,32'h0,32'h00000012},
    {1'b0,4'd6, 2'd0,32'h00003005,32'h0},           // R6 no sequential mode
    {1'b0,4'd6, 2'd1,32'h00000011,32'h0},
    {1'b0,4'd6, 2'd1,32'h00000022,32'h0},
    {1'b1,4'd6, 2'd0,32'h0,32'h00003005},
    {1'b0,4'd6, 2'd0,32'h00006005,32'h0},
    {1'b1,4'd6, 2'd1,32'h0,32'h00000022},
    {1'b0,4'd3, 2'd0,32'h00004000,32'h0},           // R3 no load flag: pointer kept
    {1'b1,4'd3, 2'd0,32'h0,32'h00004006},
    {1'b0,4'd8, 2'd0,32'h0000603E,32'h0},           // R8 write in read direction
    {1'b0,4'd8, 2'd1,32'h12345678,32'h0},
    {1'b1,4'd8, 2'd1,32'h0,32'hDEADBEEF},
    {1'b0,4'd9, 2'd0,32'h00007064,32'h0},           // R9 read in write direction
    {1'b1,4'd9, 2'd1,32'h0,32'h00000000},
    {1'b1,4'd9, 2'd0,32'h0,32'h00007064},
    {1'b0,4'd7, 2'd0,32'h000071EF,32'h0},           // R7 wrap on gain memory
    {1'b0,4'd7, 2'd1,32'hA5A5A5A5,32'h0},
    {1'b1,4'd7, 2'd0,32'h0,32'h00007000},
    {1'b0,4'd7, 2'd2,32'h0000706F,32'h0},           // R7 wrap on shift memory
    {1'b0,4'd7, 2'd3,32'h00000007,32'h0},
    {1'b1,4'd7, 2'd2,32'h0,32'h00007000},
    {1'b0,4'd2, 2'd0,32'h00006258,32'h0},           // R2 out-of-range load -> 0
    {1'b1,4'd2, 2'd0,32'h0,32'h00006000},
    {1'b0,4'd7, 2'd0,32'h000061EF,32'h0},           // R7 read wraps too
    {1'b1,4'd7, 2'd1,32'h0,32'hA5A5A5A5},
    {1'b1,4'd7, 2'd0,32'h0,32'h00006000}
  };

  // Capture of every returned word
  logic [31:0] cap [64];
  int ncap = 0;
  always @(negedge clk)
    if (!rst && bus_rvalid) begin
      if (ncap < 64) cap[ncap] = bus_rdata;
      ncap++;
    end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d, output logic v);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
    v = bus_rvalid; d = bus_rdata;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic v;
    string tag;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset values of both control registers
    rd(2'd0, d, v); check("R1 gain ctrl", d, 32'h00004000);
    rd(2'd2, d, v); check("R1 shift ctrl", d, 32'h00004000);
    check("R11 rvalid", 32'(v), 32'd1);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][70]) begin
        rd(VEC[i][65:64], d, v);
        tag = $sformatf("R%0d vector %0d", VEC[i][69:66], i);
        check(tag, d, VEC[i][31:0]);
        check({tag, " valid"}, 32'(v), 32'd1);
      end else begin
        wr(VEC[i][65:64], VEC[i][63:32]);
      end
    end

    // R4/R5: back-to-back burst of 8 writes then 8 reads, channel 3 start
    wr(2'd0, 32'h00007000 | 32'd186);
    bus_addr = 2'd1; bus_wr = 1'b1;
    for (int k = 0; k < 8; k++) begin
      bus_wdata = 32'h1000_0000 + 32'(k * 3);
      @(negedge clk);
    end
    bus_wr = 1'b0;
    rd(2'd0, d, v); check("R4 burst pointer", d, 32'h00007000 | 32'd194);
    wr(2'd0, 32'h00006000 | 32'd186);
    ncap = 0;
    bus_addr = 2'd1; bus_rd = 1'b1;
    repeat (8) @(negedge clk);
    bus_rd = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 burst valid count", 32'(ncap), 32'd8);
    for (int k = 0; k < 8; k++)
      check("R5 burst word", cap[k], 32'h1000_0000 + 32'(k * 3));

    // R12: both strobes at once
    wr(2'd0, 32'h00007000 | 32'd200);
    ncap = 0;
    bus_addr = 2'd1; bus_wdata = 32'h0BADF00D; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 no read data", 32'(ncap), 32'd0);
    wr(2'd0, 32'h00006000 | 32'd200);
    rd(2'd1, d, v); check("R12 write taken", d, 32'h0BADF00D);
    rd(2'd0, d, v); check("R12 pointer", d, 32'h00006000 | 32'd201);

    // R1: a later reset restores control registers
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    rd(2'd0, d, v); check("R1 gain ctrl after reset", d, 32'h00004000);
    rd(2'd2, d, v); check("R1 shift ctrl after reset", d, 32'h00004000);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule